// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block watches a five-stage in-order integer pipeline and decides, cycle by cycle, where the execute stage takes its operands from and which stage registers hold or clear. It compares the source register indices of the instructions in decode and execute with the destination indices of the instructions further down. From those matches it picks a bypass source for each execute operand and drives hold and clear controls for the front of the pipe.

There are three reasons to hold or clear stages. A load in execute whose result is needed by the instruction in decode inserts one bubble. A branch misprediction found in execute clears the wrong-path instructions in decode and execute. A multicycle multiply/divide unit that is still working freezes fetch, decode and execute. All three are resolved in one fixed priority order. The block is purely combinational: its outputs follow its inputs within the same cycle, and the pipeline registers around it provide the timing.

Top module: `hazard_unit`

## Requirements
- R1: Each operand select (`fwdSelA` for rs1, `fwdSelB` for rs2 in execute) reads 2'b10 when the memory-stage instruction writes the matching register. Otherwise it reads 2'b01 when the writeback-stage instruction writes it, and 2'b00 (register file) in all other cases. When both stages match, the memory stage wins.
- R2: No bypass is selected from a stage whose write enable is low, or when the register index is 0 (x0). In either case the select reads 2'b00.
- R3: Load-use: `loadE` is high, `rdE` is non-zero and equal to `rs1D` or `rs2D`, and neither busy nor mispredict is asserted. The block then raises `stallF`, `stallD` and `flushE` and keeps `stallE` and `flushD` low. With `rdE` = 0 there is no stall.
- R4: A misprediction (`mispredictE` high, `mdBusyE` low) raises `flushD` and `flushE` and keeps all three stalls low, even when a load-use hazard exists in the same cycle.
- R5: While `mdBusyE` is high, `stallF`, `stallD` and `stallE` are high and both flushes are low, whatever the load-use and mispredict inputs are.
- R6: With no load-use hazard, no misprediction and no busy unit, all five stall/flush outputs are low.
- R7: The operand selects depend only on the execute sources and the later-stage destinations. They are unchanged by the stall, flush, busy and mispredict conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1D | input | 5 | First source index of the decode instruction |
| rs2D | input | 5 | Second source index of the decode instruction |
| rs1E | input | 5 | First source index of the execute instruction |
| rs2E | input | 5 | Second source index of the execute instruction |
| rdE | input | 5 | Destination index of the execute instruction |
| loadE | input | 1 | Execute instruction is a load |
| rdM | input | 5 | Destination index of the memory-stage instruction |
| regWriteM | input | 1 | Memory-stage instruction writes the register file |
| rdW | input | 5 | Destination index of the writeback instruction |
| regWriteW | input | 1 | Writeback instruction writes the register file |
| mdBusyE | input | 1 | Multiply/divide unit in execute has not finished |
| mispredictE | input | 1 | Branch in execute was mispredicted |
| stallF | output | 1 | Hold the fetch program counter |
| stallD | output | 1 | Hold the decode stage register |
| flushD | output | 1 | Clear the decode stage register |
| stallE | output | 1 | Hold the execute stage register |
| flushE | output | 1 | Clear the execute stage register |
| fwdSelA | output | 2 | Bypass source for execute operand rs1 |
| fwdSelB | output | 2 | Bypass source for execute operand rs2 |

## Verification
The hardest cases to reach are overlaps: one cycle holding a load-use match, a misprediction and a busy divider together, or both later stages writing the same register while a third index is x0. A random stream would seldom line these up. The bench draws every register field from the set {0, 1, 2} and walks all 2187 index combinations against all 32 settings of the five flag inputs. Every aliasing, x0 and priority overlap therefore appears in that sweep.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int REG_IDX_W = 5;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  // Strobes from the compare datapath to the priority control.
  typedef struct packed {
    logic loadUseHit;
    logic mdBusy;
    logic mispredict;
  } hzd_strobe_t;
endpackage

// File: rtl/hazard_fwd_pick.sv
module hazard_fwd_pick
  import hazard_pkg::*;
#(
  parameter int IDX_W = REG_IDX_W
) (
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [IDX_W-1:0] rdM,
  input  logic             regWriteM,
  input  logic [IDX_W-1:0] rdW,
  input  logic             regWriteW,
  output fwd_sel_e         sel
);
  logic srcLive;
  logic hitMem;
  logic hitWb;

  always_comb begin
    srcLive = (srcIdx != '0);
    hitMem  = srcLive && regWriteM && (rdM == srcIdx);
    hitWb   = srcLive && regWriteW && (rdW == srcIdx);
    if (hitMem)      sel = FWD_MEM;
    else if (hitWb)  sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hazard_cmp.sv
module hazard_cmp
  import hazard_pkg::*;
#(
  parameter int IDX_W   = REG_IDX_W,
  parameter int NUM_OPS = 2
) (
  input  logic [IDX_W-1:0]         rs1D,
  input  logic [IDX_W-1:0]         rs2D,
  input  logic [NUM_OPS*IDX_W-1:0] srcE,
  input  logic [IDX_W-1:0]         rdE,
  input  logic                     loadE,
  input  logic [IDX_W-1:0]         rdM,
  input  logic                     regWriteM,
  input  logic [IDX_W-1:0]         rdW,
  input  logic                     regWriteW,
  input  logic                     mdBusyE,
  input  logic                     mispredictE,
  output logic [NUM_OPS*2-1:0]     fwdSel,
  output hzd_strobe_t              strobe
);
  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    fwd_sel_e opSel;
    hazard_fwd_pick #(.IDX_W(IDX_W)) u_pick (
      .srcIdx    (srcE[op*IDX_W +: IDX_W]),
      .rdM       (rdM),
      .regWriteM (regWriteM),
      .rdW       (rdW),
      .regWriteW (regWriteW),
      .sel       (opSel)
    );
    assign fwdSel[op*2 +: 2] = opSel;
  end

  always_comb begin
    strobe.loadUseHit = loadE && (rdE != '0) && ((rdE == rs1D) || (rdE == rs2D));
    strobe.mdBusy     = mdBusyE;
    strobe.mispredict = mispredictE;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
(
  input  hzd_strobe_t strobe,
  output logic        stallF,
  output logic        stallD,
  output logic        flushD,
  output logic        stallE,
  output logic        flushE
);
  // Priority: busy unit, then misprediction, then load-use bubble.
  always_comb begin
    stallF = 1'b0;
    stallD = 1'b0;
    flushD = 1'b0;
    stallE = 1'b0;
    flushE = 1'b0;
    if (strobe.mdBusy) begin
      stallF = 1'b1;
      stallD = 1'b1;
      stallE = 1'b1;
    end else if (strobe.mispredict) begin
      flushD = 1'b1;
      flushE = 1'b1;
    end else if (strobe.loadUseHit) begin
      stallF = 1'b1;
      stallD = 1'b1;
      flushE = 1'b1;
    end
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int IDX_W = REG_IDX_W
) (
  input  logic [IDX_W-1:0] rs1D,
  input  logic [IDX_W-1:0] rs2D,
  input  logic [IDX_W-1:0] rs1E,
  input  logic [IDX_W-1:0] rs2E,
  input  logic [IDX_W-1:0] rdE,
  input  logic             loadE,
  input  logic [IDX_W-1:0] rdM,
  input  logic             regWriteM,
  input  logic [IDX_W-1:0] rdW,
  input  logic             regWriteW,
  input  logic             mdBusyE,
  input  logic             mispredictE,
  output logic             stallF,
  output logic             stallD,
  output logic             flushD,
  output logic             stallE,
  output logic             flushE,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB
);
  localparam int NUM_OPS = 2;

  hzd_strobe_t          strobe;
  logic [NUM_OPS*2-1:0] fwdSel;

  hazard_cmp #(.IDX_W(IDX_W), .NUM_OPS(NUM_OPS)) u_cmp (
    .rs1D        (rs1D),
    .rs2D        (rs2D),
    .srcE        ({rs2E, rs1E}),
    .rdE         (rdE),
    .loadE       (loadE),
    .rdM         (rdM),
    .regWriteM   (regWriteM),
    .rdW         (rdW),
    .regWriteW   (regWriteW),
    .mdBusyE     (mdBusyE),
    .mispredictE (mispredictE),
    .fwdSel      (fwdSel),
    .strobe      (strobe)
  );

  hazard_ctrl u_ctrl (
    .strobe (strobe),
    .stallF (stallF),
    .stallD (stallD),
    .flushD (flushD),
    .stallE (stallE),
    .flushE (flushE)
  );

  assign fwdSelA = fwdSel[1:0];
  assign fwdSelB = fwdSel[3:2];
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int IDX_W = 5
) (
  input logic [IDX_W-1:0] rs1D,
  input logic [IDX_W-1:0] rs2D,
  input logic [IDX_W-1:0] rs1E,
  input logic [IDX_W-1:0] rs2E,
  input logic [IDX_W-1:0] rdE,
  input logic             loadE,
  input logic [IDX_W-1:0] rdM,
  input logic             regWriteM,
  input logic [IDX_W-1:0] rdW,
  input logic             regWriteW,
  input logic             mdBusyE,
  input logic             mispredictE,
  input logic             stallF,
  input logic             stallD,
  input logic             flushD,
  input logic             stallE,
  input logic             flushE,
  input logic [1:0]       fwdSelA,
  input logic [1:0]       fwdSelB
);
  logic luHazard;
  always_comb luHazard = loadE && (rdE != '0) && ((rdE == rs1D) || (rdE == rs2D));

  always_comb begin
    AST_MEM_WINS_A: assert (!(regWriteM && rdM != '0 && rdM == rs1E) || fwdSelA == 2'b10); // R1
    AST_MEM_WINS_B: assert (!(regWriteM && rdM != '0 && rdM == rs2E) || fwdSelB == 2'b10); // R1
    AST_X0_NO_BYPASS: assert (!(rs1E == '0) || fwdSelA == 2'b00); // R2
    AST_LOAD_BUBBLE: assert (!(luHazard && !mdBusyE && !mispredictE)
                             || (stallF && stallD && flushE && !stallE && !flushD)); // R3
    AST_MISPREDICT_FLUSH: assert (!(mispredictE && !mdBusyE)
                                  || (flushD && flushE && !stallF && !stallD && !stallE)); // R4
    AST_BUSY_FREEZE: assert (!mdBusyE || (stallF && stallD && stallE && !flushD && !flushE)); // R5
    AST_QUIET_PIPE: assert ((luHazard || mdBusyE || mispredictE)
                            || !(stallF || stallD || flushD || stallE || flushE)); // R6
  end
endmodule

bind hazard_unit hazard_unit_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] rs1D, rs2D, rs1E, rs2E, rdE, rdM, rdW;
  logic loadE, regWriteM, regWriteW, mdBusyE, mispredictE;
  logic stallF, stallD, flushD, stallE, flushE;
  logic [1:0] fwdSelA, fwdSelB;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  hazard_unit dut (.*);

  function automatic logic [1:0] expSel(input logic [4:0] src);
    if (src != 0 && regWriteM && rdM == src) return 2'b10;
    if (src != 0 && regWriteW && rdW == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic checkOne(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b (rs1D=%0d rs2D=%0d rs1E=%0d rs2E=%0d rdE=%0d rdM=%0d rdW=%0d ld=%b wm=%b ww=%b busy=%b mp=%b)",
               req, act, exp, rs1D, rs2D, rs1E, rs2E, rdE, rdM, rdW,
               loadE, regWriteM, regWriteW, mdBusyE, mispredictE);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      finishRun();
    end
  end

  initial begin
    {rs1D, rs2D, rs1E, rs2E, rdE, rdM, rdW} = '0;
    {loadE, regWriteM, regWriteW, mdBusyE, mispredictE} = '0;
    @(negedge clk);
    // Idle state: nothing pending, everything quiet (R6)
    checkOne("R6 idle", {stallF, stallD, flushD, stallE, flushE}, 5'b0);
    checkOne("R2 idle selA", {3'b0, fwdSelA}, 5'b0);
    checkOne("R2 idle selB", {3'b0, fwdSelB}, 5'b0);

    for (int f = 0; f < 32; f++) begin
      for (int c = 0; c < 2187; c++) begin
        @(negedge clk);
        {loadE, regWriteM, regWriteW, mdBusyE, mispredictE} = f[4:0];
        rs1D = 5'((c      ) % 3);
        rs2D = 5'((c /   3) % 3);
        rs1E = 5'((c /   9) % 3);
        rs2E = 5'((c /  27) % 3);
        rdE  = 5'((c /  81) % 3);
        rdM  = 5'((c / 243) % 3);
        rdW  = 5'((c / 729) % 3);
        #2;
        begin
          logic lu;
          logic [4:0] expCtl;
          string req;
          lu = loadE && rdE != 0 && (rdE == rs1D || rdE == rs2D);
          // order: stallF stallD flushD stallE flushE
          if (mdBusyE)          begin expCtl = 5'b11010; req = "R5 busy"; end
          else if (mispredictE) begin expCtl = 5'b00101; req = "R4 mispredict"; end
          else if (lu)          begin expCtl = 5'b11001; req = "R3 load-use"; end
          else                  begin expCtl = 5'b00000; req = "R6 quiet"; end
          checkOne(req, {stallF, stallD, flushD, stallE, flushE}, expCtl);
          // R1 R2 R7: selects from indices alone, whatever the control flags
          checkOne("R1/R2/R7 selA", {3'b0, fwdSelA}, {3'b0, expSel(rs1E)});
          checkOne("R1/R2/R7 selB", {3'b0, fwdSelB}, {3'b0, expSel(rs2E)});
        end
      end
    end
    done = 1'b1;
    finishRun();
  end
endmodule